// File: doc/BRIEF.md
# Two-Wire EEPROM Target Protocol Engine

This block is the bus-facing engine of a 1 KiB serial EEPROM that answers on a two-wire (I2C-style) bus. It samples the raw SCL and SDA lines on a fast system clock and finds START and STOP conditions. It reads in the select, word-address and data bytes. It acknowledges them by driving an open-drain enable on SDA, and it shifts read data out most significant bit first.

On the storage side it emits one strobe per received data byte, together with its target address. It raises a commit request when a write transaction closes with STOP. For every byte it is about to transmit it issues a read request and expects the data one cycle later. While the storage side reports a program cycle in progress, the engine ignores every select byte, so a master can poll for completion. A single address counter serves reads and writes and is kept from one transaction to the next.

Top module: `ee2w_target`

## Requirements
- R1: After reset or a STOP the engine is idle and acknowledges nothing until a START, which is SDA falling while SCL is high. A STOP is SDA rising while SCL is high.
- R2: The first byte after a START is a select byte, sent MSB first. Bits [7:4] must be 4'b1010 and bit [3] must equal `bank_sel_i`. On a match SDA is pulled low for the 9th clock. On a mismatch there is no acknowledge, and later bytes are ignored until the next START.
- R3: While `prog_busy_i` is high, a select byte is not acknowledged. Once `prog_busy_i` has fallen, the same byte is acknowledged.
- R4: Select bit [0] = 0 means write. The next byte is the word address and is acknowledged. The counter is loaded with {select bits [2:1], word address}.
- R5: Each later write byte is acknowledged and produces a one-cycle `wr_stb_o` with the counter value and the byte. Only counter bits [3:0] then increment, wrapping inside a 16-byte page; bits [9:4] stay fixed.
- R6: A STOP after at least one write data byte gives exactly one `commit_o` pulse. A STOP or repeated START with no data byte gives none.
- R7: Select bit [0] = 1 means read. The byte at the counter is sent MSB first. After each fetched byte the counter increments over the full 10 bits.
- R8: A master ACK (SDA low on the 9th clock) after a read byte makes the engine send the next byte. A NACK releases SDA and ends the read. The counter wraps from 0x3FF to 0x000.
- R9: A write select byte and word address, followed by a repeated START and a read select byte, reads from the loaded address.
- R10: The counter persists across transactions. A read with no address phase continues at the previous last access plus one, with the page rule of R5 applied after writes.
- R11: `sda_oe_o` changes only after a synchronized SCL falling edge, START or STOP. SDA input is taken on SCL rising edges.
- R12: In reset `sda_oe_o`, `wr_stb_o`, `commit_o` and `rd_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired value) |
| bank_sel_i | input | 1 | Strap compared with select bit [3] |
| prog_busy_i | input | 1 | Storage self-timed program cycle active |
| rd_data_i | input | 8 | Read byte, valid the cycle after `rd_req_o` |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wr_stb_o | output | 1 | One-cycle strobe per received write byte |
| wr_addr_o | output | 10 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed byte |
| commit_o | output | 1 | Start program cycle request |
| rd_req_o | output | 1 | One-cycle fetch request |
| rd_addr_o | output | 10 | Address of the fetch |

## Verification
A corrupted address counter shows up at the ports within one byte time. The next write strobe carries the wrong address, or the next read byte on SDA has the wrong value. The bench catches both: it checks every strobe against a queue of expected address and data pairs, and every read byte against its own memory image. A wrong FSM or bit-count state shows up within a single 9-clock slot as a missing, extra or misplaced acknowledge, which the master model compares on each byte. A spurious commit is caught on the clock it appears. A wrong busy gate is caught on the first select byte of the polling sequence.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_RACK
  } ee_state_e;

  localparam logic [3:0] SEL_PREFIX = 4'b1010;
endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, syn, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign syn[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '1;
    else         prev <= syn;
  end

  assign sda_o      = syn[0];
  assign scl_rise_o = syn[1] & ~prev[1];
  assign scl_fall_o = ~syn[1] & prev[1];
  assign start_o    = syn[1] & prev[1] & prev[0] & ~syn[0];
  assign stop_o     = syn[1] & prev[1] & ~prev[0] & syn[0];
endmodule

// File: rtl/ee2w_addr_cnt.sv
module ee2w_addr_cnt #(
  parameter int AW     = 10,
  parameter int PAGE_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          inc_page_i,
  input  logic          inc_full_i,
  output logic [AW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= '0;
    else if (ld_i)       cnt_o <= ld_val_i;
    else if (inc_page_i) cnt_o <= {cnt_o[AW-1:PAGE_W], cnt_o[PAGE_W-1:0] + 1'b1};
    else if (inc_full_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ee2w_ctrl.sv
module ee2w_ctrl
  import ee2w_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic          bank_sel_i,
  input  logic          prog_busy_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    rd_data_i,
  output logic          ld_o,
  output logic [AW-1:0] ld_val_o,
  output logic          inc_page_o,
  output logic          inc_full_o,
  output logic          sda_oe_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          commit_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);
  localparam int HI_W = AW - 8;

  ee_state_e       state;
  logic [2:0]      bit_cnt;
  logic [7:0]      rx_sh, tx_sh, rx_byte;
  logic [HI_W-1:0] hi_q;
  logic            ack_arm, in_ack, rd_mode, wrote, nxt_rd, rd_wait;
  logic            rx_state, byte_done, sel_ok, rack_ack;

  assign rx_state  = (state == ST_SEL) || (state == ST_WADR) || (state == ST_WDAT);
  assign rx_byte   = {rx_sh[6:0], sda_i};
  assign byte_done = !start_i && !stop_i && rx_state && scl_rise_i && !in_ack && (bit_cnt == 3'd7);
  assign sel_ok    = (rx_byte[7:4] == SEL_PREFIX) && (rx_byte[3] == bank_sel_i) && !prog_busy_i;
  assign rack_ack  = !start_i && !stop_i && (state == ST_RACK) && scl_rise_i && !sda_i;

  assign ld_o       = byte_done && (state == ST_WADR);
  assign ld_val_o   = {hi_q, rx_byte};
  assign inc_page_o = byte_done && (state == ST_WDAT);
  assign inc_full_o = (byte_done && (state == ST_SEL) && sel_ok && rx_byte[0]) || rack_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      hi_q      <= '0;
      ack_arm   <= 1'b0;
      in_ack    <= 1'b0;
      rd_mode   <= 1'b0;
      wrote     <= 1'b0;
      nxt_rd    <= 1'b0;
      rd_wait   <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      commit_o  <= 1'b0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      commit_o <= 1'b0;
      rd_req_o <= 1'b0;
      rd_wait  <= rd_req_o;
      if (rd_wait) tx_sh <= rd_data_i;

      if (start_i) begin
        state    <= ST_SEL;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
        ack_arm  <= 1'b0;
        in_ack   <= 1'b0;
        nxt_rd   <= 1'b0;
        wrote    <= 1'b0;
      end else if (stop_i) begin
        if (state == ST_WDAT && wrote) commit_o <= 1'b1;
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        ack_arm  <= 1'b0;
        in_ack   <= 1'b0;
        nxt_rd   <= 1'b0;
        wrote    <= 1'b0;
      end else begin
        unique case (state)
          ST_SEL, ST_WADR, ST_WDAT: begin
            if (scl_rise_i && !in_ack) begin
              rx_sh   <= rx_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (state == ST_SEL) begin
                  if (sel_ok) begin
                    ack_arm <= 1'b1;
                    hi_q    <= rx_byte[HI_W:1];
                    rd_mode <= rx_byte[0];
                    if (rx_byte[0]) begin
                      rd_req_o  <= 1'b1;
                      rd_addr_o <= addr_i;
                    end
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_WADR) begin
                  ack_arm <= 1'b1;
                end else begin
                  ack_arm   <= 1'b1;
                  wr_stb_o  <= 1'b1;
                  wr_addr_o <= addr_i;
                  wr_data_o <= rx_byte;
                  wrote     <= 1'b1;
                end
              end
            end
            if (scl_fall_i) begin
              if (ack_arm) begin
                sda_oe_o <= 1'b1;
                in_ack   <= 1'b1;
                ack_arm  <= 1'b0;
              end else if (in_ack) begin
                in_ack <= 1'b0;
                if (state == ST_SEL && rd_mode) begin
                  state    <= ST_RDAT;
                  sda_oe_o <= ~tx_sh[7];
                end else begin
                  sda_oe_o <= 1'b0;
                  if (state == ST_SEL)       state <= ST_WADR;
                  else if (state == ST_WADR) state <= ST_WDAT;
                end
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall_i && bit_cnt != 3'd0) sda_oe_o <= ~tx_sh[3'd7 - bit_cnt];
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                state  <= ST_RACK;
                nxt_rd <= 1'b0;
              end
            end
          end
          ST_RACK: begin
            if (scl_fall_i) begin
              if (nxt_rd) begin
                state    <= ST_RDAT;
                nxt_rd   <= 1'b0;
                sda_oe_o <= ~tx_sh[7];
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
            if (scl_rise_i) begin
              if (!sda_i) begin
                rd_req_o  <= 1'b1;
                rd_addr_o <= addr_i;
                nxt_rd    <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ee2w_target.sv
module ee2w_target #(
  parameter int AW          = 10,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          bank_sel_i,
  input  logic          prog_busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          commit_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ld, inc_page, inc_full;
  logic [AW-1:0] ld_val, addr;

  ee2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  ee2w_addr_cnt #(.AW(AW), .PAGE_W(PAGE_W)) u_cnt (
    .clk_i, .rst_ni, .ld_i(ld), .ld_val_i(ld_val),
    .inc_page_i(inc_page), .inc_full_i(inc_full), .cnt_o(addr)
  );

  ee2w_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_i(sda_s),
    .bank_sel_i, .prog_busy_i, .addr_i(addr), .rd_data_i,
    .ld_o(ld), .ld_val_o(ld_val), .inc_page_o(inc_page), .inc_full_o(inc_full),
    .sda_oe_o, .wr_stb_o, .wr_addr_o, .wr_data_o, .commit_o, .rd_req_o, .rd_addr_o
  );
endmodule

// File: rtl/ee2w_target_chk.sv
module ee2w_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_fall_i,
  input logic start_i,
  input logic stop_i,
  input logic sda_oe_i,
  input logic wr_stb_i,
  input logic commit_i,
  input logic rd_req_i,
  input logic prog_busy_i
);
  a_r11_oe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> $past(scl_fall_i || start_i || stop_i));

  a_r6_commit_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(stop_i));

  a_r3_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |-> !prog_busy_i);

  a_r5_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !wr_stb_i);

  a_r7_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> !rd_req_i);
endmodule

bind ee2w_target ee2w_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall_i(scl_fall), .start_i(start_det),
  .stop_i(stop_det), .sda_oe_i(sda_oe_o), .wr_stb_i(wr_stb_o), .commit_i(commit_o),
  .rd_req_i(rd_req_o), .prog_busy_i(prog_busy_i)
);

// File: tb/ee2w_target_test.sv
module ee2w_target_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1;
  logic       sda_oe, wr_stb, commit, rd_req, busy;
  logic [9:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire        sda_bus = sda_m & ~sda_oe;

  int tot = 0, bad = 0, glitches = 0, busy_cnt = 0, exp_commit = 0;
  bit done = 0;
  logic [7:0]  mem [1024];
  logic [7:0]  exp_mem [1024];
  logic [17:0] exp_wq [$];
  logic [9:0]  st_a [$];
  logic [7:0]  st_d [$];
  logic [9:0]  exp_ptr;

  always #2.5 clk = ~clk;

  ee2w_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .bank_sel_i(1'b1), .prog_busy_i(busy), .rd_data_i(rd_data),
    .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .commit_o(commit), .rd_req_o(rd_req), .rd_addr_o(rd_addr)
  );

  assign busy = (busy_cnt != 0);

  // storage-side model: staged writes, commit, timed busy, one-cycle read latency
  always @(posedge clk) begin
    if (rd_req) rd_data <= mem[rd_addr];
    if (wr_stb) begin st_a.push_back(wr_addr); st_d.push_back(wr_data); end
    if (commit) begin
      while (st_a.size() > 0) mem[st_a.pop_front()] = st_d.pop_front();
      busy_cnt <= 300;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic check(string r, int act, int exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // per-clock comparison against the expected strobe and commit stream
  always @(negedge clk) if (rst_n && !done) begin
    if (wr_stb) begin
      if (exp_wq.size() == 0) check("R5 unexpected strobe", {wr_addr, wr_data}, 0);
      else check("R5 strobe addr/data", {wr_addr, wr_data}, exp_wq.pop_front());
    end
    if (commit) begin
      check("R6 commit expected", int'(exp_commit > 0), 1);
      if (exp_commit > 0) exp_commit--;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    scl = 1'b0; tick(4); sda_m = 1'b1; tick(4); scl = 1'b1; tick(4); sda_m = 1'b0; tick(4);
  endtask

  task automatic m_stop;
    scl = 1'b0; tick(4); sda_m = 1'b0; tick(4); scl = 1'b1; tick(4); sda_m = 1'b1; tick(4);
  endtask

  task automatic m_bit(input logic b, output logic r);
    logic r2;
    scl = 1'b0; tick(4); sda_m = b; tick(4); scl = 1'b1; tick(2);
    r = sda_bus; tick(1); r2 = sda_bus; tick(1);
    if (r !== r2) glitches++;
  endtask

  task automatic m_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rdbyte(input logic more, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin m_bit(1'b1, r); d = {d[6:0], r}; end
    m_bit(~more, r);
  endtask

  function automatic logic [7:0] sel_byte(input logic [1:0] hi, input logic rd);
    return {4'b1010, 1'b1, hi, rd};
  endfunction

  task automatic wr_page(input logic [9:0] a, input int n, input logic [7:0] seed);
    logic ak;
    logic [9:0] p;
    logic [7:0] d;
    m_start;
    m_byte(sel_byte(a[9:8], 1'b0), ak); check("R2 select ack", ak, 1);
    m_byte(a[7:0], ak);                 check("R4 address ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 7);
      p = {a[9:4], 4'(a[3:0] + 4'(i))};
      exp_wq.push_back({p, d});
      exp_mem[p] = d;
      m_byte(d, ak); check("R5 data ack", ak, 1);
    end
    exp_ptr = {a[9:4], 4'(a[3:0] + 4'(n))};
    exp_commit++;
    m_stop;
  endtask

  task automatic rd_seq(input int n, input string r);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      m_rdbyte(i < n - 1, d);
      check(r, d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 10'd1;
    end
    m_stop;
  endtask

  task automatic cur_rd(input int n, input string r);
    logic ak;
    m_start;
    m_byte(sel_byte(2'b00, 1'b1), ak); check("R7 read select ack", ak, 1);
    rd_seq(n, r);
  endtask

  task automatic rand_rd(input logic [9:0] a, input int n, input string r);
    logic ak;
    m_start;
    m_byte(sel_byte(a[9:8], 1'b0), ak); check("R9 dummy select ack", ak, 1);
    m_byte(a[7:0], ak);                 check("R9 dummy address ack", ak, 1);
    exp_ptr = a;
    m_start;
    m_byte(sel_byte(2'b00, 1'b1), ak);  check("R9 read select ack", ak, 1);
    rd_seq(n, r);
  endtask

  initial begin
    logic ak;
    for (int i = 0; i < 1024; i++) begin
      mem[i]     = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end
    rd_data = '0;
    tick(3);
    check("R12 reset oe", sda_oe, 0);
    check("R12 reset strobe", wr_stb, 0);
    check("R12 reset commit", commit, 0);
    check("R12 reset rd_req", rd_req, 0);
    rst_n = 1'b1;
    tick(10);

    // R1: bytes without START are ignored
    m_byte(sel_byte(2'b00, 1'b0), ak); check("R1 no start no ack", ak, 0);
    m_stop;
    // R2: wrong strap bit, wrong prefix, standby after mismatch
    m_start;
    m_byte(8'b1010_0000, ak); check("R2 strap mismatch nack", ak, 0);
    m_byte(sel_byte(2'b00, 1'b0), ak); check("R2 ignored until start", ak, 0);
    m_stop;
    m_start;
    m_byte(8'b1011_1000, ak); check("R2 prefix mismatch nack", ak, 0);
    m_stop;

    // R4/R5/R6 byte write at 0x123 via select high bits
    wr_page(10'h123, 1, 8'h5A);
    // R3 acknowledge polling
    m_start;
    m_byte(sel_byte(2'b00, 1'b0), ak); check("R3 busy select nack", ak, 0);
    m_stop;
    tick(400);
    m_start;
    m_byte(sel_byte(2'b00, 1'b0), ak); check("R3 select ack after busy", ak, 1);
    m_stop; // R6: no data, no commit

    // R9 random read, then R10 current-address continuation
    rand_rd(10'h123, 1, "R9 random read data");
    cur_rd(2, "R10 current read continues");

    // R5 page roll: 18 bytes from column 14
    wr_page(10'h2FE, 18, 8'h11);
    tick(400);
    cur_rd(3, "R10 counter after page roll");
    rand_rd(10'h2F0, 16, "R5 page content after roll");

    // R8 full-array wrap in a sequential read
    rand_rd(10'h3FE, 4, "R8 sequential wrap");
    // R8 NACK ends read; later bytes without START ignored
    m_byte(sel_byte(2'b00, 1'b1), ak); check("R8 idle after nack", ak, 0);
    m_stop;

    tick(20);
    done = 1;
    check("R11 sda stable while scl high", glitches, 0);
    check("R5 all strobes seen", exp_wq.size(), 0);
    check("R6 all commits seen", exp_commit, 0);
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tot++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end
endmodule